// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs one transfer at a time on a bus whose low address bits and data share the same lines. A requester presents an operation code, a byte address, a byte/word size and, for stores, write data. The controller then walks the fixed clock states T1, T2, T3 (plus any wait states) and T4. It drives the shared lines, the address strobe, the transceiver controls, the lane-select and space-select outputs, the read, write and interrupt-acknowledge strobes, and a 3-bit cycle status code.

The responding device holds the ready input low to stretch a cycle. Each low sample adds one wait state (Tw) between T3 and T4. Read data is taken from the shared lines at the close of T4, steered to the low end of the result according to size and address parity, and returned with a one-cycle valid pulse. A new request is taken only in an idle cycle, so there is always at least one idle cycle between two bus cycles.

All strobes are active high. The shared lines are modelled as a separate output, output-enable and input.

Top module: `busseq_ctrl`

## Requirements
- R1: After a synchronous reset, all strobes and enables are low, `status` is 3'b111, `req_ready` is high and `rsp_valid` is low.
- R2: `req_op` codes are 0 memory read, 1 memory write, 2 I/O read, 3 I/O write, 4 opcode fetch and 5 interrupt acknowledge. A request with code 6 or 7 is ignored: no cycle starts and `req_ready` stays high.
- R3: In T1, which is the first cycle after acceptance, `ale` is high for exactly that one cycle, `ad_oe` is high, `ad_out` carries the address low bits and `addr_hi` carries the address upper bits. `addr_hi` is zero in every other cycle.
- R4: `status` carries the cycle code from T1 through the last T3/Tw: 101 memory read, 110 memory write, 001 I/O read, 010 I/O write, 100 opcode fetch, 000 interrupt acknowledge. It is 111 in T4 and when idle.
- R5: From T1 through T4, `m_io` is high only for I/O codes and `dt_r` is high only for writes. Both are low when idle.
- R6: For non-write cycles, `ad_oe` is low from T2 to T4. `rd` (or `inta` for code 5) is high in T2, T3 and every Tw. `den` is high from T2 to T4 for every cycle.
- R7: For writes, `ad_oe` stays high from T2 to T4 with the write data on `ad_out`, and `wr` is high in T2, T3 and every Tw.
- R8: `bus_ready` is sampled at the end of T3 and of each Tw. A low sample adds one Tw, so a cycle lasts 4 + (number of low samples) clocks.
- R9: `bhe` is high from T1 to T4 when the request is a word or the address is odd. A byte write places its byte on both lanes, and a word write drives all data bits.
- R10: For non-write cycles, `ad_in` is captured at the end of T4 and `rsp_valid` pulses in the next cycle. A word returns the full bus, an even byte returns the low lane, and an odd byte returns the high lane, each zero-extended.
- R11: `req_ready` is high only in idle cycles. It is low from T1 through T4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this edge |
| req_op | input | 3 | Operation code |
| req_addr | input | ADDR_W | Byte address |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_wdata | input | 2*LANE_W | Write data |
| bus_ready | input | 1 | Device ready; low inserts a wait state |
| ad_in | input | 2*LANE_W | Shared lines as seen from the bus |
| ad_out | output | 2*LANE_W | Value driven onto shared lines |
| ad_oe | output | 1 | Shared line output enable |
| addr_hi | output | ADDR_W-2*LANE_W | Upper address bits, T1 only |
| ale | output | 1 | Address valid pulse |
| den | output | 1 | Transceiver enable |
| dt_r | output | 1 | 1 = data transmitted out |
| bhe | output | 1 | Upper byte lane in use |
| m_io | output | 1 | 1 = I/O space |
| rd | output | 1 | Read strobe |
| wr | output | 1 | Write strobe |
| inta | output | 1 | Interrupt acknowledge strobe |
| status | output | 3 | Cycle status code |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | 2*LANE_W | Read result |

## Verification
The bench uses the default parameters: LANE_W = 8 and ADDR_W = 20. That gives two byte lanes and a 4-bit upper address field, so even-byte, odd-byte and word steering are all reachable, and the upper address bits appear separately in T1. Wait counts of zero to five exercise both the T3 and the repeated Tw ready samples. All six legal codes and both illegal codes are driven, with a behavioural model compared against every output on every clock.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;

  localparam logic [2:0] OPC_MEM_RD = 3'd0;
  localparam logic [2:0] OPC_MEM_WR = 3'd1;
  localparam logic [2:0] OPC_IO_RD  = 3'd2;
  localparam logic [2:0] OPC_IO_WR  = 3'd3;
  localparam logic [2:0] OPC_FETCH  = 3'd4;
  localparam logic [2:0] OPC_INTA   = 3'd5;

  localparam logic [2:0] STS_PASSIVE = 3'b111;

  typedef struct packed {
    logic [2:0] code;
    logic       io;
    logic       write;
    logic       ack;
    logic       legal;
  } opinfo_t;

endpackage

// File: rtl/busseq_decode.sv
module busseq_decode
  import busseq_pkg::*;
(
  input  logic [2:0] op,
  output opinfo_t    info
);
  always_comb begin
    info = '{code: STS_PASSIVE, io: 1'b0, write: 1'b0, ack: 1'b0, legal: 1'b0};
    case (op)
      OPC_MEM_RD: info = '{code: 3'b101, io: 1'b0, write: 1'b0, ack: 1'b0, legal: 1'b1};
      OPC_MEM_WR: info = '{code: 3'b110, io: 1'b0, write: 1'b1, ack: 1'b0, legal: 1'b1};
      OPC_IO_RD:  info = '{code: 3'b001, io: 1'b1, write: 1'b0, ack: 1'b0, legal: 1'b1};
      OPC_IO_WR:  info = '{code: 3'b010, io: 1'b1, write: 1'b1, ack: 1'b0, legal: 1'b1};
      OPC_FETCH:  info = '{code: 3'b100, io: 1'b0, write: 1'b0, ack: 1'b0, legal: 1'b1};
      OPC_INTA:   info = '{code: 3'b000, io: 1'b0, write: 1'b0, ack: 1'b1, legal: 1'b1};
      default:    info = '{code: STS_PASSIVE, io: 1'b0, write: 1'b0, ack: 1'b0, legal: 1'b0};
    endcase
  end
endmodule

// File: rtl/busseq_lanes.sv
module busseq_lanes #(
  parameter int LANE_W = 8,
  localparam int NLANE = 2,
  localparam int BUS_W = NLANE * LANE_W
) (
  input  logic             word,
  input  logic             odd,
  input  logic [BUS_W-1:0] wdata,
  input  logic [BUS_W-1:0] rbus,
  output logic             hi_en,
  output logic [BUS_W-1:0] wbus,
  output logic [BUS_W-1:0] rdata
);
  // Write steering: a byte is replicated onto every lane.
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign wbus[g*LANE_W +: LANE_W] = word ? wdata[g*LANE_W +: LANE_W]
                                           : wdata[LANE_W-1:0];
  end

  assign hi_en = word | odd;

  always_comb begin
    if (word)     rdata = rbus;
    else if (odd) rdata = {{(BUS_W-LANE_W){1'b0}}, rbus[BUS_W-1 -: LANE_W]};
    else          rdata = {{(BUS_W-LANE_W){1'b0}}, rbus[LANE_W-1:0]};
  end
endmodule

// File: rtl/busseq_fsm.sv
module busseq_fsm
  import busseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   bus_ready,
  output phase_e ph,
  output phase_e ph_nxt
);
  always_comb begin
    ph_nxt = ph;
    case (ph)
      PH_IDLE:      if (start) ph_nxt = PH_T1;
      PH_T1:        ph_nxt = PH_T2;
      PH_T2:        ph_nxt = PH_T3;
      PH_T3, PH_TW: ph_nxt = bus_ready ? PH_T4 : PH_TW;
      PH_T4:        ph_nxt = PH_IDLE;
      default:      ph_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ph <= PH_IDLE;
    else     ph <= ph_nxt;
  end

  // R8: a low ready sample in T3 or Tw yields another Tw
  a_r8_wait_inserted: assert property (@(posedge clk) disable iff (rst)
    ((ph == PH_T3 || ph == PH_TW) && !bus_ready) |=> (ph == PH_TW));
  // R8: a high ready sample moves on to T4
  a_r8_wait_released: assert property (@(posedge clk) disable iff (rst)
    ((ph == PH_T3 || ph == PH_TW) && bus_ready) |=> (ph == PH_T4));
  // R11: T4 always returns to idle
  a_r11_t4_to_idle: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_T4) |=> (ph == PH_IDLE));
endmodule

// File: rtl/busseq_ctrl.sv
module busseq_ctrl
  import busseq_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int ADDR_W = 20,
  localparam int AD_W  = 2 * LANE_W,
  localparam int HI_W  = ADDR_W - AD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic [AD_W-1:0]   req_wdata,
  input  logic              bus_ready,
  input  logic [AD_W-1:0]   ad_in,
  output logic [AD_W-1:0]   ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   addr_hi,
  output logic              ale,
  output logic              den,
  output logic              dt_r,
  output logic              bhe,
  output logic              m_io,
  output logic              rd,
  output logic              wr,
  output logic              inta,
  output logic [2:0]        status,
  output logic              rsp_valid,
  output logic [AD_W-1:0]   rsp_data
);
  phase_e ph, ph_nxt;

  logic [2:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic              word_q;
  logic [AD_W-1:0]   wdata_q;

  opinfo_t in_info, cur_info;
  logic    accept;

  busseq_decode u_dec_in (.op(req_op), .info(in_info));

  assign req_ready = (ph == PH_IDLE);
  assign accept    = req_valid && req_ready && in_info.legal;

  // Current request: taken from the inputs on the accepting edge, held after.
  logic [2:0]        cur_op;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_word;
  logic [AD_W-1:0]   cur_wdata;

  always_comb begin
    cur_op    = accept ? req_op    : op_q;
    cur_addr  = accept ? req_addr  : addr_q;
    cur_word  = accept ? req_word  : word_q;
    cur_wdata = accept ? req_wdata : wdata_q;
  end

  busseq_decode u_dec_cur (.op(cur_op), .info(cur_info));

  logic            hi_en;
  logic [AD_W-1:0] wbus, rdata_c;

  busseq_lanes #(.LANE_W(LANE_W)) u_lanes (
    .word (cur_word),
    .odd  (cur_addr[0]),
    .wdata(cur_wdata),
    .rbus (ad_in),
    .hi_en(hi_en),
    .wbus (wbus),
    .rdata(rdata_c)
  );

  busseq_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .bus_ready(bus_ready),
    .ph       (ph),
    .ph_nxt   (ph_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= '0;
      addr_q  <= '0;
      word_q  <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      op_q    <= req_op;
      addr_q  <= req_addr;
      word_q  <= req_word;
      wdata_q <= req_wdata;
    end
  end

  // Phase groups of the state being entered; every pin is a flop.
  logic n_t1, n_mid, n_data, n_act;
  always_comb begin
    n_t1   = (ph_nxt == PH_T1);
    n_mid  = (ph_nxt == PH_T2) || (ph_nxt == PH_T3) || (ph_nxt == PH_TW);
    n_data = n_mid || (ph_nxt == PH_T4);
    n_act  = (ph_nxt != PH_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_out    <= '0;
      ad_oe     <= 1'b0;
      addr_hi   <= '0;
      ale       <= 1'b0;
      den       <= 1'b0;
      dt_r      <= 1'b0;
      bhe       <= 1'b0;
      m_io      <= 1'b0;
      rd        <= 1'b0;
      wr        <= 1'b0;
      inta      <= 1'b0;
      status    <= STS_PASSIVE;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      ale     <= n_t1;
      ad_oe   <= n_t1 || (cur_info.write && n_data);
      if (n_t1)                       ad_out <= cur_addr[AD_W-1:0];
      else if (cur_info.write && n_data) ad_out <= wbus;
      else                            ad_out <= '0;
      addr_hi <= n_t1 ? cur_addr[ADDR_W-1:AD_W] : '0;
      den     <= n_data;
      dt_r    <= n_act && cur_info.write;
      bhe     <= n_act && hi_en;
      m_io    <= n_act && cur_info.io;
      rd      <= n_mid && !cur_info.write && !cur_info.ack;
      wr      <= n_mid && cur_info.write;
      inta    <= n_mid && cur_info.ack;
      status  <= (n_t1 || n_mid) ? cur_info.code : STS_PASSIVE;
      rsp_valid <= (ph == PH_T4) && !cur_info.write;
      if ((ph == PH_T4) && !cur_info.write) rsp_data <= rdata_c;
    end
  end

  // R3: the address strobe lasts a single clock
  a_r3_ale_single: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);
  // R11: a cycle only starts out of an idle cycle
  a_r11_start_from_idle: assert property (@(posedge clk) disable iff (rst)
    ale |-> $past(req_ready));
  // R4: status is passive whenever the sequencer sits in T4
  a_r4_passive_t4: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_T4) |-> (status == STS_PASSIVE));
  // R6: the controller never drives the lines while a read strobe is up
  a_r6_release_on_read: assert property (@(posedge clk) disable iff (rst)
    (rd || inta) |-> !ad_oe);
  // R7: at most one transfer strobe at a time
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd, wr, inta}));
  // R10: read data is announced only right after T4
  a_r10_rsp_after_t4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(ph == PH_T4));
endmodule

// File: tb/test_busseq_ctrl.sv
module test_busseq_ctrl;
  localparam int LANE_W = 8;
  localparam int ADDR_W = 20;
  localparam int AD_W   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [2:0]        req_op = 3'd0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_word = 1'b0;
  logic [AD_W-1:0]   req_wdata = '0;
  logic              bus_ready = 1'b1;
  logic [AD_W-1:0]   ad_in = '0;
  logic [AD_W-1:0]   ad_out;
  logic              ad_oe;
  logic [3:0]        addr_hi;
  logic ale, den, dt_r, bhe, m_io, rd, wr, inta;
  logic [2:0]        status;
  logic              rsp_valid;
  logic [AD_W-1:0]   rsp_data;

  busseq_ctrl #(.LANE_W(LANE_W), .ADDR_W(ADDR_W)) i_busseq_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_word(req_word),
    .req_wdata(req_wdata), .bus_ready(bus_ready), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi), .ale(ale),
    .den(den), .dt_r(dt_r), .bhe(bhe), .m_io(m_io), .rd(rd), .wr(wr),
    .inta(inta), .status(status), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  int checks = 0;
  int failures = 0;
  bit run_chk = 1'b0;
  bit done = 1'b0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string req, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 T1, 2 T2, 3 T3, 4 Tw, 5 T4
  int              m_ph = 0;
  logic [2:0]      m_op = 3'd0;
  logic [19:0]     m_addr = '0;
  logic            m_word = 1'b0;
  logic [15:0]     m_wd = '0;
  logic            m_rspv = 1'b0;
  logic [15:0]     m_rsp = '0;

  function automatic logic is_wr(input logic [2:0] op);
    return (op == 3'd1) || (op == 3'd3);
  endfunction

  function automatic logic [2:0] code_of(input logic [2:0] op);
    case (op)
      3'd0: return 3'b101;
      3'd1: return 3'b110;
      3'd2: return 3'b001;
      3'd3: return 3'b010;
      3'd4: return 3'b100;
      3'd5: return 3'b000;
      default: return 3'b111;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0;
      m_rspv = 1'b0;
    end else begin
      m_rspv = 1'b0;
      case (m_ph)
        0: if (req_valid && req_op < 3'd6) begin
             m_ph = 1; m_op = req_op; m_addr = req_addr;
             m_word = req_word; m_wd = req_wdata;
           end
        1: m_ph = 2;
        2: m_ph = 3;
        3, 4: m_ph = bus_ready ? 5 : 4;
        default: begin
          m_ph = 0;
          if (!is_wr(m_op)) begin
            m_rspv = 1'b1;
            if (m_word) m_rsp = ad_in;
            else if (m_addr[0]) m_rsp = {8'h00, ad_in[15:8]};
            else m_rsp = {8'h00, ad_in[7:0]};
          end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (run_chk) begin
      logic t1, mid, dph, act, w, io, ack;
      t1  = (m_ph == 1);
      mid = (m_ph == 2) || (m_ph == 3) || (m_ph == 4);
      dph = mid || (m_ph == 5);
      act = (m_ph != 0);
      w   = is_wr(m_op);
      io  = (m_op == 3'd2) || (m_op == 3'd3);
      ack = (m_op == 3'd5);
      chk(req_ready, m_ph == 0, "R11", "req_ready");
      chk(ale, t1, "R3", "ale");
      chk(addr_hi, t1 ? m_addr[19:16] : 4'h0, "R3", "addr_hi");
      chk(ad_oe, t1 || (w && dph), w ? "R7" : "R6", "ad_oe");
      if (t1) chk(ad_out, m_addr[15:0], "R3", "ad_out address");
      else if (w && dph)
        chk(ad_out, m_word ? m_wd : {m_wd[7:0], m_wd[7:0]}, "R9", "ad_out write data");
      chk(status, (t1 || mid) ? code_of(m_op) : 3'b111, "R4", "status");
      chk(m_io, act && io, "R5", "m_io");
      chk(dt_r, act && w, "R5", "dt_r");
      chk(den, dph, "R6", "den");
      chk(rd, mid && !w && !ack, "R6", "rd");
      chk(inta, mid && ack, "R6", "inta");
      chk(wr, mid && w, "R7", "wr");
      chk(bhe, act && (m_word || m_addr[0]), "R9", "bhe");
      chk(rsp_valid, m_rspv, "R10", "rsp_valid");
      if (m_rspv) chk(rsp_data, m_rsp, "R10", "rsp_data");
    end
  end

  task automatic run_cycle(input logic [2:0] op, input logic [19:0] addr,
                           input logic word, input logic [15:0] wd,
                           input int waits, input logic [15:0] din);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_word = word;
    req_wdata = wd; ad_in = din; bus_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (req_ready == 1'b0) begin
      n++;
      if (n >= 3) bus_ready = ((n - 3) >= waits);
      @(negedge clk);
    end
    bus_ready = 1'b1;
    chk(n, 4 + waits, "R8", "cycle length in clocks");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk({ale, rd, wr, inta, den, ad_oe, dt_r, bhe, m_io}, 9'h0, "R1", "strobes after reset");
    chk(status, 3'b111, "R1", "status after reset");
    chk(req_ready, 1'b1, "R1", "req_ready after reset");
    chk(rsp_valid, 1'b0, "R1", "rsp_valid after reset");
    run_chk = 1'b1;

    run_cycle(3'd0, 20'h43210, 1'b1, 16'h0000, 0, 16'hBEEF);
    run_cycle(3'd1, 20'h2A224, 1'b1, 16'h5A3C, 1, 16'h0000);
    run_cycle(3'd2, 20'h00081, 1'b0, 16'h0000, 2, 16'hC7E1);
    run_cycle(3'd3, 20'h00046, 1'b0, 16'h00D2, 0, 16'h0000);
    run_cycle(3'd4, 20'hFFFF0, 1'b1, 16'h0000, 3, 16'h90EB);
    run_cycle(3'd5, 20'h00000, 1'b0, 16'h0000, 0, 16'h3308);
    run_cycle(3'd0, 20'h12346, 1'b0, 16'h0000, 5, 16'hA17F);
    run_cycle(3'd1, 20'h9ABC7, 1'b0, 16'h1166, 0, 16'h0000);

    // R2: codes 6 and 7 start nothing
    begin
      int ales;
      ales = 0;
      @(negedge clk);
      req_valid = 1'b1;
      for (int k = 6; k < 8; k++) begin
        req_op = 3'(k);
        repeat (3) begin
          @(negedge clk);
          if (ale) ales++;
          chk(req_ready, 1'b1, "R2", "req_ready with illegal code");
        end
      end
      req_valid = 1'b0;
      chk(ales, 0, "R2", "address strobes for illegal codes");
    end

    run_cycle(3'd2, 20'h00FFF, 1'b1, 16'h0000, 1, 16'h6E4D);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule